// File: doc/BRIEF.md
# Pulse-Injection Channel Response Checker

This block runs a self-test on a bank of front-end channels. A test is launched with a start pulse. The start pulse comes with a channel selection mask, a pulse count, a spacing between pulses and a settle length. The block first zeroes one hit counter per channel. It then drives a train of single-cycle injection strobes toward the analog test-pulse circuitry. After the last strobe it waits a settle period so that late hits can still arrive. Finally it compares every counter against the pulse count in a single cycle.

The outcome of the test is given in two forms. A one-bit pass flag states whether every selected channel saw exactly the number of pulses that was injected. A per-channel failure map shows which channels did not. All channels are counted and judged at the same time. A full test therefore takes one strobe train plus a short fixed overhead, whatever the number of channels.

Top module: `inj_resp_checker`

## Requirements
- R1: Every hit counter is cleared when a test is accepted. Counters advance only from the first strobe cycle through the end of the settle period. Hits seen before a test, or left over from an earlier test, never affect a result.
- R2: An accepted test with pulse count N drives exactly N strobes on `inj_strobe`, and each strobe is high for one cycle. N = 0 produces no strobe.
- R3: The first strobe is high in the second cycle after the cycle in which `start` is sampled high. Consecutive strobes are separated by max(`strobe_gap`, 1) low cycles.
- R4: `done` is high max(`settle_len`, 8) + 2 cycles after the cycle of the last strobe. With N = 0, `done` is high max(`settle_len`, 8) + 3 cycles after the cycle in which `start` was sampled.
- R5: A selected channel passes only when its count equals N exactly. Fewer or more hits set its bit in `fail_map` (bit i = 1 means channel i failed).
- R6: A channel whose `chan_mask` bit is 0 is not tested. Its `fail_map` bit reads 0 and it has no effect on `pass`. `pass` is 1 exactly when no tested channel failed, including when the mask is all zero.
- R7: The hit counters saturate at their all-ones value instead of wrapping.
- R8: `busy` is high from the cycle after `start` is accepted until the cycle before `done`. `done` is a one-cycle pulse during which `busy` is low. `pass` and `fail_map` change only when `done` is raised and hold their values until the next result.
- R9: A `start` pulse while a test is running is ignored. Changes to the configuration inputs after acceptance have no effect on the running test.
- R10: After reset, `inj_strobe`, `busy`, `done`, `pass` and `fail_map` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a test; accepted only while idle |
| chan_mask | input | NCH | Bit i = 1 selects channel i for testing |
| pulse_count | input | CNT_W | Number of strobes to inject (N) |
| strobe_gap | input | GAP_W | Low cycles between strobes; 0 is treated as 1 |
| settle_len | input | SET_W | Settle cycles after the last strobe; raised to at least 8 |
| hit_in | input | NCH | Per-channel hit indication, counted once per high cycle |
| inj_strobe | output | 1 | Single-cycle injection strobe |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle pulse when results become valid |
| pass | output | 1 | All tested channels matched the pulse count |
| fail_map | output | NCH | Bit i = 1 means tested channel i failed |

## Verification
The bench sweeps the pulse count, the gap and the settle length over a small configuration. This includes gap 0 and settle values below the floor of 8, where a design that forgot to clamp would emit merged strobes or report results before late hits land. Per-channel fault models cover a missing pulse, one extra pulse and a continuously firing channel. They catch a comparison that tolerates off-by-one counts, ignores a high count, or lets masked faulty channels leak into `pass`. A saturation case injects the maximum count while a noisy channel far exceeds it; a wrapping counter would report that channel as failed. A second start pulse arriving mid-test, together with changed configuration inputs, exposes a sequencer that restarts or re-samples its settings.

// File: rtl/inj_chk_pkg.sv
package inj_chk_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CLEAR,
    S_STROBE,
    S_GAP,
    S_SETTLE,
    S_COMPARE
  } seq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hit_scaler.sv
module hit_scaler #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en && hit && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;

  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt_q));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/inj_sequencer.sv
module inj_sequencer
  import inj_chk_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int GAP_W      = 8,
  parameter int SET_W      = 8,
  parameter int MIN_SETTLE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] pulse_count,
  input  logic [GAP_W-1:0] strobe_gap,
  input  logic [SET_W-1:0] settle_len,
  output logic             accept,
  output logic             busy,
  output logic             inj_strobe,
  output logic             clr,
  output logic             cnt_en,
  output logic             cmp_en
);

  localparam int TMR_W = imax(GAP_W, SET_W);
  localparam logic [SET_W-1:0] SET_FLOOR = SET_W'(MIN_SETTLE);

  seq_state_t       st_q;
  logic [CNT_W-1:0] rem_q;
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] gap_ld_q;
  logic [TMR_W-1:0] set_ld_q;

  assign accept = start && (st_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      rem_q    <= '0;
      tmr_q    <= '0;
      gap_ld_q <= '0;
      set_ld_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start) begin
            st_q     <= S_CLEAR;
            rem_q    <= pulse_count;
            gap_ld_q <= (strobe_gap == '0) ? '0 : TMR_W'(strobe_gap) - 1'b1;
            set_ld_q <= (settle_len < SET_FLOOR) ? TMR_W'(SET_FLOOR) - 1'b1
                                                 : TMR_W'(settle_len) - 1'b1;
          end
        end
        S_CLEAR: begin
          if (rem_q == '0) begin
            st_q  <= S_SETTLE;
            tmr_q <= set_ld_q;
          end else begin
            st_q <= S_STROBE;
          end
        end
        S_STROBE: begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            st_q  <= S_SETTLE;
            tmr_q <= set_ld_q;
          end else begin
            st_q  <= S_GAP;
            tmr_q <= gap_ld_q;
          end
        end
        S_GAP: begin
          if (tmr_q == '0) st_q <= S_STROBE;
          else             tmr_q <= tmr_q - 1'b1;
        end
        S_SETTLE: begin
          if (tmr_q == '0) st_q <= S_COMPARE;
          else             tmr_q <= tmr_q - 1'b1;
        end
        S_COMPARE: st_q <= S_IDLE;
        default:   st_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign inj_strobe = (st_q == S_STROBE);
  assign clr        = (st_q == S_CLEAR);
  assign cnt_en     = (st_q == S_STROBE) || (st_q == S_GAP) || (st_q == S_SETTLE);
  assign cmp_en     = (st_q == S_COMPARE);

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    inj_strobe |=> !inj_strobe);

  assert_no_extra_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_STROBE) |-> (rem_q != '0));

  assert_settle_floor_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_STROBE && rem_q == CNT_W'(1)) |=>
      (st_q == S_SETTLE && tmr_q >= TMR_W'(MIN_SETTLE - 1)));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && st_q != S_COMPARE) |=> busy);

endmodule

// File: rtl/resp_compare.sv
module resp_compare #(
  parameter int NCH   = 16,
  parameter int CNT_W = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [NCH-1:0]            mask,
  input  logic [CNT_W-1:0]          expected,
  input  logic                      cmp_en,
  input  logic [NCH-1:0][CNT_W-1:0] cnt,
  output logic                      done,
  output logic                      pass,
  output logic [NCH-1:0]            fail_map
);

  logic [NCH-1:0]   mask_q;
  logic [CNT_W-1:0] exp_q;
  logic [NCH-1:0]   miss;

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign miss[i] = mask_q[i] && (cnt[i] != exp_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      exp_q    <= '0;
      done     <= 1'b0;
      pass     <= 1'b0;
      fail_map <= '0;
    end else begin
      done <= cmp_en;
      if (load) begin
        mask_q <= mask;
        exp_q  <= expected;
      end
      if (cmp_en) begin
        fail_map <= miss;
        pass     <= ~|miss;
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/inj_resp_checker.sv
module inj_resp_checker #(
  parameter int NCH        = 16,
  parameter int CNT_W      = 24,
  parameter int GAP_W      = 8,
  parameter int SET_W      = 8,
  parameter int MIN_SETTLE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NCH-1:0]   chan_mask,
  input  logic [CNT_W-1:0] pulse_count,
  input  logic [GAP_W-1:0] strobe_gap,
  input  logic [SET_W-1:0] settle_len,
  input  logic [NCH-1:0]   hit_in,
  output logic             inj_strobe,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [NCH-1:0]   fail_map
);

  logic accept, clr, cnt_en, cmp_en;
  logic [NCH-1:0][CNT_W-1:0] cnt_w;

  inj_sequencer #(
    .CNT_W(CNT_W), .GAP_W(GAP_W), .SET_W(SET_W), .MIN_SETTLE(MIN_SETTLE)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start),
    .pulse_count(pulse_count), .strobe_gap(strobe_gap), .settle_len(settle_len),
    .accept(accept), .busy(busy), .inj_strobe(inj_strobe),
    .clr(clr), .cnt_en(cnt_en), .cmp_en(cmp_en)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    hit_scaler #(.CNT_W(CNT_W)) scaler_i (
      .clk(clk), .rst(rst), .clr(clr), .en(cnt_en),
      .hit(hit_in[i]), .cnt(cnt_w[i])
    );
  end

  resp_compare #(.NCH(NCH), .CNT_W(CNT_W)) cmp_i (
    .clk(clk), .rst(rst), .load(accept), .mask(chan_mask),
    .expected(pulse_count), .cmp_en(cmp_en), .cnt(cnt_w),
    .done(done), .pass(pass), .fail_map(fail_map)
  );

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

endmodule

// File: tb/inj_resp_checker_tb_top.sv
module inj_resp_checker_tb_top;

  localparam int NCH = 16;
  localparam int CW  = 6;
  localparam int GW  = 4;
  localparam int SW  = 5;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NCH-1:0] chan_mask = '0;
  logic [CW-1:0]  pulse_count = '0;
  logic [GW-1:0]  strobe_gap = '0;
  logic [SW-1:0]  settle_len = '0;
  logic [NCH-1:0] hit_in;
  logic inj_strobe, busy, done, pass;
  logic [NCH-1:0] fail_map;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int seen = 0;
  int lim [NCH];
  bit dbl [NCH];
  bit noisy [NCH];
  logic [2:0] dly;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  inj_resp_checker #(
    .NCH(NCH), .CNT_W(CW), .GAP_W(GW), .SET_W(SW), .MIN_SETTLE(8)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .chan_mask(chan_mask),
    .pulse_count(pulse_count), .strobe_gap(strobe_gap), .settle_len(settle_len),
    .hit_in(hit_in), .inj_strobe(inj_strobe), .busy(busy), .done(done),
    .pass(pass), .fail_map(fail_map)
  );

  // Channel model: each channel echoes the strobe two cycles later, with faults
  initial begin
    hit_in = '0;
    dly = '0;
    forever begin
      @(negedge clk);
      dly = {dly[1:0], inj_strobe};
      for (int i = 0; i < NCH; i++) begin
        logic h;
        h = noisy[i];
        if (dly[1] && seen < lim[i]) h = 1'b1;
        if (dly[2] && seen == 1 && dbl[i]) h = 1'b1;
        hit_in[i] = h;
      end
      if (dly[1]) seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i < NCH; i++) begin
      lim[i] = 999;
      dbl[i] = 1'b0;
      noisy[i] = 1'b0;
    end
  endtask

  task automatic run_test(input logic [NCH-1:0] m, input int n, input int g,
                          input int s, input bit mid);
    int geff, seff, win, t0, nstb, first, last, tdone, c;
    bit got, gap_ok, busy_ok;
    logic [NCH-1:0] expmap;
    logic [NCH-1:0] held;
    geff = (g == 0) ? 1 : g;
    seff = (s < 8) ? 8 : s;
    win = (n > 0) ? n + (n - 1) * geff + seff : seff;
    expmap = '0;
    for (int i = 0; i < NCH; i++) begin
      c = noisy[i] ? win : (((lim[i] < n) ? lim[i] : n) + ((dbl[i] && n > 0) ? 1 : 0));
      if (c > CMAX) c = CMAX;
      if (m[i] && c != n) expmap[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    seen = 0;
    @(negedge clk);
    chan_mask = m; pulse_count = CW'(n); strobe_gap = GW'(g); settle_len = SW'(s);
    start = 1'b1;
    t0 = cyc;
    got = 0; gap_ok = 1; busy_ok = 1; nstb = 0; first = -1; last = -1; tdone = -1;
    for (int k = 0; k < 3000 && !got; k++) begin
      @(negedge clk);
      start = 1'b0;
      chan_mask = ~m; pulse_count = CW'(n + 1); strobe_gap = GW'(g + 3); settle_len = SW'(s + 5);
      if (mid && cyc == t0 + 4) start = 1'b1;   // R9 stimulus
      if (inj_strobe) begin
        if (nstb == 0) first = cyc;
        else if (cyc - last != geff + 1) gap_ok = 0;
        last = cyc;
        nstb++;
      end
      if (done) begin
        got = 1;
        tdone = cyc;
      end else if (busy !== 1'b1) busy_ok = 0;
    end
    start = 1'b0;
    chk(got, "R8 done seen", got, 1);
    chk(nstb == n, "R2 strobe count", nstb, n);
    if (n > 0) begin
      chk(first == t0 + 2, "R3 first strobe cycle", first - t0, 2);
      chk(gap_ok, "R3 strobe spacing", gap_ok, 1);
      chk(tdone - last == seff + 2, "R4 settle after last strobe", tdone - last, seff + 2);
    end else begin
      chk(tdone - t0 == seff + 3, "R4 settle with zero pulses", tdone - t0, seff + 3);
    end
    chk(busy_ok && busy === 1'b0, "R8 busy window", {busy_ok, busy}, 2);
    chk(fail_map === expmap, "R5 R6 fail_map", fail_map, expmap);
    chk(pass === (expmap == '0), "R5 R6 pass", pass, expmap == '0);
    held = fail_map;
    @(negedge clk);
    chk(done === 1'b0, "R8 done single cycle", done, 0);
    repeat (2) @(negedge clk);
    chk(fail_map === held, "R8 result hold", fail_map, held);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_faults();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({inj_strobe, busy, done, pass} == 4'b0 && fail_map == '0, "R10 reset state",
        {inj_strobe, busy, done, pass, fail_map}, 0);

    // Clean run, all channels selected
    run_test('1, 5, 2, 10, 0);

    // R5: missing pulse on ch3, extra pulse on ch7; gap 0 and settle 0 clamp
    clear_faults(); lim[3] = 3; dbl[7] = 1'b1;
    run_test('1, 4, 0, 0, 0);
    // R6: same faults, masked out
    run_test(16'hFF77, 4, 0, 0, 0);
    run_test(16'hFFF7, 4, 1, 3, 0);
    run_test('0, 4, 1, 3, 0);

    // Noisy channel fails; R1: a later clean test must not inherit its counts
    clear_faults(); noisy[0] = 1'b1;
    run_test('1, 10, 1, 9, 0);
    clear_faults();
    run_test('1, 10, 1, 9, 0);

    // R7: saturation at maximum count
    clear_faults(); noisy[5] = 1'b1; lim[6] = 62;
    run_test('1, CMAX, 0, 0, 0);

    // Zero pulses: good channels pass, a noisy channel fails
    clear_faults();
    run_test('1, 0, 2, 12, 0);
    noisy[1] = 1'b1;
    run_test('1, 0, 2, 12, 0);

    // R9: start while busy and changed inputs ignored
    clear_faults(); lim[9] = 2;
    run_test('1, 6, 3, 8, 1);

    // Sweep count, gap, settle with deterministic faults
    for (int n = 1; n <= 6; n++) begin
      for (int g = 0; g <= 3; g++) begin
        for (int si = 0; si < 2; si++) begin
          int ch;
          clear_faults();
          ch = (n * 3 + g) % NCH;
          lim[ch] = n - 1;
          dbl[(ch + 5) % NCH] = 1'b1;
          run_test(16'hFFFF ^ (16'h1 << ((n + g) % NCH)), n, g, si ? 9 : 0, (n + g) % 3 == 0);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule